// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block sequences program and erase operations on an embedded flash array. It runs on the dedicated flash timing clock, which is expected to lie between 257 kHz and 476 kHz. Every duration is a fixed number of cycles of that clock rather than an absolute time. A host issues one of four commands: single word/byte program, block (burst) program, segment erase or mass erase. The sequencer then drives the program, erase and high-voltage strobes of the array for hardwired cycle counts. It reports busy, wait (ready for the next block datum) and a one-cycle done pulse.

The block also keeps a budget of the cumulative program time spent on the current block since the last erase. Program work that would push this total over a parameterised limit is refused, and a sticky flag is raised. The limit defaults to 4760 cycles, which is 10 ms at the fastest timing clock. The block flags commands that arrive while it is busy and otherwise ignores them. An emergency-exit input drops all strobes at once and returns the sequencer to idle with a failure status.

Top module: `flash_pe_timer`

## Requirements
- R1: A word program command (`cmd_op` = 0), accepted at a clock edge while idle, holds `prog_en` and `hv_en` high for exactly 35 cycles starting at that edge. `done` then pulses for one cycle as the sequencer returns to idle.
- R2: A block program command (`cmd_op` = 1) programs the first datum with `prog_en` high for 30 cycles and then raises `wait_rdy`. Each `dat_valid` seen while `wait_rdy` is high starts a further 21-cycle `prog_en` pulse. `hv_en` stays high without a break from the start of the block to its end.
- R3: `blk_end` seen while `wait_rdy` is high starts a 6-cycle end sequence with only `hv_en` high, followed by `done`. `blk_end` takes priority over `dat_valid`. After the 32nd datum of a block, the end sequence follows directly without waiting.
- R4: A segment erase command (`cmd_op` = 2) holds `erase_en` and `hv_en` high for 4819 cycles, then pulses `done`.
- R5: A mass erase command (`cmd_op` = 3) holds `erase_en` and `hv_en` high for 5297 cycles, then pulses `done`.
- R6: Accepted program work adds 35 cycles (word), 30 cycles (first block datum) or 21 cycles (each further datum) to a budget. The sequencer refuses a program command or datum that would take the budget above 4760, or that arrives while `cum_viol` is set. A refused command leaves `busy` low. A refused datum sends the block to its end sequence. In both cases `cum_viol` is set and stays set.
- R7: Accepting either erase command empties the budget and clears `cum_viol`, so program commands are accepted again.
- R8: A command arriving while `busy` is high sets the sticky `acc_viol` flag. The operation in progress continues with unchanged timing.
- R9: `abort` while busy returns the sequencer to idle at the next edge. At that edge all strobes drop and `fail` is set, and no `done` pulse is produced. `abort` while idle has no effect.
- R10: Any command presented while idle clears `fail` and `acc_viol`.
- R11: During and after reset, and whenever idle, `prog_en`, `erase_en`, `hv_en`, `busy` and `wait_rdy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flash timing clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe, sampled each edge |
| cmd_op | input | 2 | 0 word program, 1 block program, 2 segment erase, 3 mass erase |
| dat_valid | input | 1 | Next block datum present |
| blk_end | input | 1 | Host ends block mode |
| abort | input | 1 | Emergency exit |
| prog_en | output | 1 | Array program strobe |
| erase_en | output | 1 | Array erase strobe |
| hv_en | output | 1 | High-voltage enable |
| busy | output | 1 | Operation in progress |
| wait_rdy | output | 1 | Block mode ready for next datum |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last operation aborted (sticky) |
| acc_viol | output | 1 | Command issued while busy (sticky) |
| cum_viol | output | 1 | Program budget exceeded (sticky) |

## Verification
All outputs are decoded from registers only. A command, datum, end request or abort sampled at a rising edge therefore shows on the strobes and flags right after that same edge, and an N-cycle phase keeps its strobe high for N consecutive cycles. `done` rises at the edge that ends the last active cycle, so it coincides with the first idle cycle. The bench model advances on each rising edge from the same sampled inputs and compares all nine outputs at the following falling edge. Directed checks measure strobe widths, done counts and flags at falling edges after the accepting edge.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

    typedef enum logic [1:0] {
        OP_WORD  = 2'd0,
        OP_BLOCK = 2'd1,
        OP_SEG   = 2'd2,
        OP_MASS  = 2'd3
    } fsq_op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WORD,
        PH_BFIRST,
        PH_BWAIT,
        PH_BNEXT,
        PH_BEND,
        PH_SEG,
        PH_MASS
    } fsq_ph_e;

    typedef enum logic [1:0] {
        CHG_NONE,
        CHG_WORD,
        CHG_FIRST,
        CHG_NEXT
    } fsq_chg_e;

    function automatic int unsigned fsq_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsq_prog_budget.sv
module fsq_prog_budget
    import fsq_pkg::*;
#(
    parameter int unsigned LIMIT     = 4760,
    parameter int unsigned WORD_CYC  = 35,
    parameter int unsigned FIRST_CYC = 30,
    parameter int unsigned NEXT_CYC  = 21
) (
    input  logic     clk,
    input  logic     rst_n,
    input  fsq_chg_e chg,
    input  logic     clr,
    input  logic     refuse,
    output logic     fit_word,
    output logic     fit_first,
    output logic     fit_next,
    output logic     viol
);

    localparam int unsigned AW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          viol;
    } bud_t;

    bud_t bud_q, bud_d;

    // Room check: no sticky violation and the cost still fits in the limit
    assign fit_word  = !bud_q.viol && ((32'(bud_q.acc) + WORD_CYC)  <= LIMIT);
    assign fit_first = !bud_q.viol && ((32'(bud_q.acc) + FIRST_CYC) <= LIMIT);
    assign fit_next  = !bud_q.viol && ((32'(bud_q.acc) + NEXT_CYC)  <= LIMIT);
    assign viol      = bud_q.viol;

    always_comb begin
        bud_d = bud_q;
        if (clr) begin
            bud_d = '0;
        end else begin
            if (refuse) bud_d.viol = 1'b1;
            case (chg)
                CHG_WORD:  bud_d.acc = bud_q.acc + AW'(WORD_CYC);
                CHG_FIRST: bud_d.acc = bud_q.acc + AW'(FIRST_CYC);
                CHG_NEXT:  bud_d.acc = bud_q.acc + AW'(NEXT_CYC);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bud_q <= '0;
        else        bud_q <= bud_d;
    end

    // R6
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(bud_q.acc) <= LIMIT);

    // R6
    charge_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg == CHG_NEXT) |-> fit_next);

    // R7
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (bud_q.acc == '0 && !bud_q.viol));

endmodule

// File: rtl/fsq_phase_ctrl.sv
module fsq_phase_ctrl
    import fsq_pkg::*;
#(
    parameter int unsigned WORD_CYC  = 35,
    parameter int unsigned FIRST_CYC = 30,
    parameter int unsigned NEXT_CYC  = 21,
    parameter int unsigned END_CYC   = 6,
    parameter int unsigned SEG_CYC   = 4819,
    parameter int unsigned MASS_CYC  = 5297,
    parameter int unsigned BLK_MAX   = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       dat_valid,
    input  logic       blk_end,
    input  logic       abort,
    input  logic       fit_word,
    input  logic       fit_first,
    input  logic       fit_next,
    output fsq_ph_e    ph,
    output logic       done,
    output logic       fail,
    output logic       acc_viol,
    output fsq_chg_e   chg,
    output logic       bud_clr,
    output logic       bud_refuse
);

    localparam int unsigned LONGEST = fsq_max(fsq_max(fsq_max(WORD_CYC, FIRST_CYC),
                                                      fsq_max(NEXT_CYC, END_CYC)),
                                              fsq_max(SEG_CYC, MASS_CYC));
    localparam int unsigned CW = $clog2(LONGEST + 1);
    localparam int unsigned NW = $clog2(BLK_MAX + 1);

    typedef struct packed {
        fsq_ph_e       ph;
        logic [CW-1:0] cnt;
        logic [NW-1:0] nwr;
        logic          done;
        logic          fail;
        logic          acc_viol;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic last_cyc;

    function automatic logic [CW-1:0] span(int unsigned n);
        return CW'(n - 1);
    endfunction

    assign last_cyc = (ctl_q.cnt == '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        chg        = CHG_NONE;
        bud_clr    = 1'b0;
        bud_refuse = 1'b0;
        if (abort && ctl_q.ph != PH_IDLE) begin
            ctl_d.ph   = PH_IDLE;
            ctl_d.fail = 1'b1;
        end else if (ctl_q.ph == PH_IDLE) begin
            if (cmd_valid) begin
                ctl_d.fail     = 1'b0;
                ctl_d.acc_viol = 1'b0;
                case (fsq_op_e'(cmd_op))
                    OP_WORD: begin
                        if (fit_word) begin
                            ctl_d.ph  = PH_WORD;
                            ctl_d.cnt = span(WORD_CYC);
                            chg       = CHG_WORD;
                        end else begin
                            bud_refuse = 1'b1;
                        end
                    end
                    OP_BLOCK: begin
                        if (fit_first) begin
                            ctl_d.ph  = PH_BFIRST;
                            ctl_d.cnt = span(FIRST_CYC);
                            ctl_d.nwr = NW'(1);
                            chg       = CHG_FIRST;
                        end else begin
                            bud_refuse = 1'b1;
                        end
                    end
                    OP_SEG: begin
                        ctl_d.ph  = PH_SEG;
                        ctl_d.cnt = span(SEG_CYC);
                        bud_clr   = 1'b1;
                    end
                    default: begin
                        ctl_d.ph  = PH_MASS;
                        ctl_d.cnt = span(MASS_CYC);
                        bud_clr   = 1'b1;
                    end
                endcase
            end
        end else begin
            if (cmd_valid) ctl_d.acc_viol = 1'b1;
            case (ctl_q.ph)
                PH_BWAIT: begin
                    if (blk_end) begin
                        ctl_d.ph  = PH_BEND;
                        ctl_d.cnt = span(END_CYC);
                    end else if (dat_valid) begin
                        if (fit_next) begin
                            ctl_d.ph  = PH_BNEXT;
                            ctl_d.cnt = span(NEXT_CYC);
                            ctl_d.nwr = ctl_q.nwr + NW'(1);
                            chg       = CHG_NEXT;
                        end else begin
                            bud_refuse = 1'b1;
                            ctl_d.ph   = PH_BEND;
                            ctl_d.cnt  = span(END_CYC);
                        end
                    end
                end
                PH_BFIRST, PH_BNEXT: begin
                    if (last_cyc) begin
                        if (ctl_q.nwr == NW'(BLK_MAX)) begin
                            ctl_d.ph  = PH_BEND;
                            ctl_d.cnt = span(END_CYC);
                        end else begin
                            ctl_d.ph = PH_BWAIT;
                        end
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - CW'(1);
                    end
                end
                default: begin
                    if (last_cyc) begin
                        ctl_d.ph   = PH_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt - CW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ph       = ctl_q.ph;
    assign done     = ctl_q.done;
    assign fail     = ctl_q.fail;
    assign acc_viol = ctl_q.acc_viol;

    // R8
    busy_cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph != PH_IDLE && cmd_valid && !abort) |=> ctl_q.acc_viol);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph != PH_IDLE && abort) |=> (ctl_q.ph == PH_IDLE && ctl_q.fail && !ctl_q.done));

    // R1
    done_after_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> ($past(ctl_q.ph) != PH_IDLE && ctl_q.ph == PH_IDLE));

    // R2
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.ph == PH_BWAIT) |-> ($past(ctl_q.ph) == PH_BFIRST || $past(ctl_q.ph) == PH_BNEXT));

    // R8
    busy_op_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_WORD && !last_cyc && !abort) |=> ctl_q.ph == PH_WORD);

endmodule

// File: rtl/fsq_strobe_map.sv
module fsq_strobe_map
    import fsq_pkg::*;
(
    input  fsq_ph_e ph,
    output logic    prog_en,
    output logic    erase_en,
    output logic    hv_en,
    output logic    busy,
    output logic    wait_rdy
);

    always_comb begin
        prog_en  = 1'b0;
        erase_en = 1'b0;
        hv_en    = 1'b1;
        busy     = 1'b1;
        wait_rdy = 1'b0;
        case (ph)
            PH_IDLE: begin
                hv_en = 1'b0;
                busy  = 1'b0;
            end
            PH_WORD, PH_BFIRST, PH_BNEXT: prog_en  = 1'b1;
            PH_BWAIT:                     wait_rdy = 1'b1;
            PH_SEG, PH_MASS:              erase_en = 1'b1;
            default:                      ;
        endcase
    end

endmodule

// File: rtl/flash_pe_timer.sv
module flash_pe_timer
    import fsq_pkg::*;
#(
    parameter int unsigned WORD_CYC  = 35,
    parameter int unsigned FIRST_CYC = 30,
    parameter int unsigned NEXT_CYC  = 21,
    parameter int unsigned END_CYC   = 6,
    parameter int unsigned SEG_CYC   = 4819,
    parameter int unsigned MASS_CYC  = 5297,
    parameter int unsigned BLK_MAX   = 32,
    parameter int unsigned LIMIT     = 4760
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       dat_valid,
    input  logic       blk_end,
    input  logic       abort,
    output logic       prog_en,
    output logic       erase_en,
    output logic       hv_en,
    output logic       busy,
    output logic       wait_rdy,
    output logic       done,
    output logic       fail,
    output logic       acc_viol,
    output logic       cum_viol
);

    fsq_ph_e  ph;
    fsq_chg_e chg;
    logic     bud_clr, bud_refuse;
    logic     fit_word, fit_first, fit_next;

    fsq_phase_ctrl #(
        .WORD_CYC (WORD_CYC),
        .FIRST_CYC(FIRST_CYC),
        .NEXT_CYC (NEXT_CYC),
        .END_CYC  (END_CYC),
        .SEG_CYC  (SEG_CYC),
        .MASS_CYC (MASS_CYC),
        .BLK_MAX  (BLK_MAX)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dat_valid (dat_valid),
        .blk_end   (blk_end),
        .abort     (abort),
        .fit_word  (fit_word),
        .fit_first (fit_first),
        .fit_next  (fit_next),
        .ph        (ph),
        .done      (done),
        .fail      (fail),
        .acc_viol  (acc_viol),
        .chg       (chg),
        .bud_clr   (bud_clr),
        .bud_refuse(bud_refuse)
    );

    fsq_prog_budget #(
        .LIMIT    (LIMIT),
        .WORD_CYC (WORD_CYC),
        .FIRST_CYC(FIRST_CYC),
        .NEXT_CYC (NEXT_CYC)
    ) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg      (chg),
        .clr      (bud_clr),
        .refuse   (bud_refuse),
        .fit_word (fit_word),
        .fit_first(fit_first),
        .fit_next (fit_next),
        .viol     (cum_viol)
    );

    fsq_strobe_map u_map (
        .ph      (ph),
        .prog_en (prog_en),
        .erase_en(erase_en),
        .hv_en   (hv_en),
        .busy    (busy),
        .wait_rdy(wait_rdy)
    );

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hv_en && !prog_en && !erase_en && !wait_rdy));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_en && erase_en));

    // R2
    hv_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || erase_en || wait_rdy) |-> hv_en);

    // R6
    refuse_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op[1] == 1'b0 && cum_viol) |=> !busy);

endmodule

// File: tb/sim_flash_pe_timer.sv
module sim_flash_pe_timer;

    localparam int CLK_PERIOD = 10;
    localparam int D_WORD = 35, D_FIRST = 30, D_NEXT = 21, D_END = 6;
    localparam int D_SEG = 4819, D_MASS = 5297, BLK = 32, LIM = 4760;
    localparam int MI = 0, MW = 1, MF = 2, MWT = 3, MN = 4, ME = 5, MS = 6, MM = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, dat_valid = 1'b0, blk_end = 1'b0, abort = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic prog_en, erase_en, hv_en, busy, wait_rdy, done, fail, acc_viol, cum_viol;

    int n_chk = 0, n_bad = 0, n_done = 0;
    bit fin = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_pe_timer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .dat_valid(dat_valid), .blk_end(blk_end), .abort(abort),
        .prog_en(prog_en), .erase_en(erase_en), .hv_en(hv_en), .busy(busy),
        .wait_rdy(wait_rdy), .done(done), .fail(fail), .acc_viol(acc_viol),
        .cum_viol(cum_viol)
    );

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    int m_ph = MI, m_left = 0, m_dat = 0, m_bud = 0;
    bit m_cv = 0, m_av = 0, m_fail = 0, m_done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = MI; m_left = 0; m_dat = 0; m_bud = 0;
            m_cv = 0; m_av = 0; m_fail = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (abort && m_ph != MI) begin
                m_ph = MI; m_fail = 1;
            end else if (m_ph == MI) begin
                if (cmd_valid) begin
                    m_av = 0; m_fail = 0;
                    if (cmd_op == 2'd0) begin
                        if (!m_cv && m_bud + D_WORD <= LIM) begin
                            m_bud += D_WORD; m_ph = MW; m_left = D_WORD;
                        end else m_cv = 1;
                    end else if (cmd_op == 2'd1) begin
                        if (!m_cv && m_bud + D_FIRST <= LIM) begin
                            m_bud += D_FIRST; m_ph = MF; m_left = D_FIRST; m_dat = 1;
                        end else m_cv = 1;
                    end else begin
                        m_bud = 0; m_cv = 0;
                        m_ph = (cmd_op == 2'd2) ? MS : MM;
                        m_left = (cmd_op == 2'd2) ? D_SEG : D_MASS;
                    end
                end
            end else begin
                if (cmd_valid) m_av = 1;
                if (m_ph == MWT) begin
                    if (blk_end) begin
                        m_ph = ME; m_left = D_END;
                    end else if (dat_valid) begin
                        if (!m_cv && m_bud + D_NEXT <= LIM) begin
                            m_bud += D_NEXT; m_dat++; m_ph = MN; m_left = D_NEXT;
                        end else begin
                            m_cv = 1; m_ph = ME; m_left = D_END;
                        end
                    end
                end else begin
                    m_left--;
                    if (m_left == 0) begin
                        if (m_ph == MF || m_ph == MN) begin
                            if (m_dat == BLK) begin m_ph = ME; m_left = D_END; end
                            else m_ph = MWT;
                        end else begin
                            m_ph = MI; m_done = 1;
                        end
                    end
                end
            end
        end
    end

    function automatic string ph_tag(int p);
        case (p)
            MW: return "R1";
            MF, MWT, MN: return "R2";
            ME: return "R3";
            MS: return "R4";
            MM: return "R5";
            default: return "R11";
        endcase
    endfunction

    // Per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (!fin) begin
            logic [8:0] e, a;
            e = {(m_ph == MW || m_ph == MF || m_ph == MN), (m_ph == MS || m_ph == MM),
                 (m_ph != MI), (m_ph != MI), (m_ph == MWT), m_done, m_fail, m_av, m_cv};
            a = {prog_en, erase_en, hv_en, busy, wait_rdy, done, fail, acc_viol, cum_viol};
            chk(ph_tag(m_ph), int'(a), int'(e), "model compare {prog,erase,hv,busy,wait,done,fail,accv,cumv}");
        end
    end

    // Strobe width recorders
    int pw[$], ew[$], hw[$];
    int pc = 0, ec = 0, hc = 0;
    always @(negedge clk) begin
        if (prog_en) pc++; else if (pc > 0) begin pw.push_back(pc); pc = 0; end
        if (erase_en) ec++; else if (ec > 0) begin ew.push_back(ec); ec = 0; end
        if (hv_en) hc++; else if (hc > 0) begin hw.push_back(hc); hc = 0; end
        if (done) n_done++;
    end

    task automatic clearq();
        pw.delete(); ew.delete(); hw.delete();
    endtask

    task automatic issue(int op);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'(op);
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic pulse_dat();
        @(negedge clk); dat_valid = 1'b1;
        @(negedge clk); dat_valid = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); blk_end = 1'b1;
        @(negedge clk); blk_end = 1'b0;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 200 && !wait_rdy; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 7000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        chk("R11", int'({prog_en, erase_en, hv_en, busy, wait_rdy}), 0, "strobes in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R9: abort while idle has no effect
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R9", int'(fail), 0, "fail after idle abort");

        // R1 / R8: word program, with an erase command arriving mid-way
        clearq(); d0 = n_done;
        issue(0);
        repeat (5) @(negedge clk);
        issue(2);
        chk("R8", int'(acc_viol), 1, "acc_viol after busy command");
        wait_idle();
        chk("R1", pw.size(), 1, "word program pulse count");
        if (pw.size() > 0) chk("R1", pw[0], D_WORD, "word prog_en width");
        chk("R8", ew.size(), 0, "no erase from busy command");
        chk("R1", n_done - d0, 1, "done pulses for word");

        // R10: an idle command clears acc_viol
        issue(0);
        chk("R10", int'(acc_viol), 0, "acc_viol cleared");
        wait_idle();

        // R2 / R3: block of three data ended by the host
        clearq();
        issue(1);
        wait_ready(); pulse_dat();
        wait_ready(); pulse_dat();
        wait_ready(); pulse_end();
        wait_idle();
        chk("R2", pw.size(), 3, "block prog pulses");
        if (pw.size() == 3) begin
            chk("R2", pw[0], D_FIRST, "first datum width");
            chk("R2", pw[2], D_NEXT, "later datum width");
        end
        chk("R2", hw.size(), 1, "hv_en unbroken");
        if (hw.size() > 0) chk("R3", hw[0], 84, "hv width incl. end sequence");

        // R3: block that reaches the datum limit ends by itself
        clearq();
        issue(1);
        for (int k = 0; k < BLK - 1; k++) begin wait_ready(); pulse_dat(); end
        wait_idle();
        chk("R3", pw.size(), BLK, "data in full block");
        if (hw.size() > 0) chk("R3", hw[0], D_FIRST + (BLK - 1) * (D_NEXT + 2) + D_END, "full block hv width");

        // R4 / R5: erase durations
        clearq();
        issue(2); wait_idle();
        if (ew.size() > 0) chk("R4", ew[0], D_SEG, "segment erase width");
        issue(3); wait_idle();
        if (ew.size() > 1) chk("R5", ew[1], D_MASS, "mass erase width");
        chk("R5", ew.size(), 2, "erase pulse count");

        // R6: budget fills up with word writes
        for (int k = 0; k < LIM / D_WORD; k++) begin issue(0); wait_idle(); end
        chk("R6", int'(cum_viol), 0, "budget exactly full");
        issue(0);
        chk("R6", int'(busy), 0, "word refused over budget");
        chk("R6", int'(cum_viol), 1, "cum_viol set");
        issue(1);
        chk("R6", int'(busy), 0, "block refused while sticky");

        // R7: erase clears the budget
        issue(2);
        chk("R7", int'(cum_viol), 0, "cum_viol cleared by erase");
        wait_idle();
        issue(0);
        chk("R7", int'(busy), 1, "word accepted after erase");
        wait_idle();

        // R6: a block datum that would exceed the budget ends the block
        for (int k = 0; k < 133; k++) begin issue(0); wait_idle(); end
        clearq();
        issue(1);
        wait_ready(); pulse_dat();
        wait_ready(); pulse_dat();
        chk("R6", int'(cum_viol), 1, "datum refused over budget");
        chk("R6", int'({prog_en, wait_rdy}), 0, "end sequence after refused datum");
        wait_idle();
        chk("R6", pw.size(), 2, "program pulses in refused block");

        // R9 / R10: abort during an erase
        issue(2);
        repeat (100) @(negedge clk);
        d0 = n_done;
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk("R9", int'({busy, hv_en, erase_en}), 0, "strobes dropped by abort");
        chk("R9", int'(fail), 1, "fail after abort");
        repeat (3) @(negedge clk);
        chk("R9", n_done - d0, 0, "no done after abort");
        issue(0);
        chk("R10", int'(fail), 0, "fail cleared by command");
        chk("R10", int'(busy), 1, "word accepted after abort");
        wait_idle();

        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule